// File: doc/BRIEF.md
# Dual-port DRAM access arbiter

This block lets two independent bus ports, A and B, share one dynamic RAM array. Each port presents read and write request lines together with an enable qualifier. The arbiter picks one port at a time and starts a RAM cycle through a one-cycle start pulse to a separate timing sequencer. It then waits for that sequencer's done input and answers the served port with a one-cycle acknowledge.

Two steering outputs leave the block. The address-mux select routes the granted port's row and column address to the RAM. It may move toward a waiting port before the cycle ends, once a programmable column-address hold window has passed. The data-port select, paired with an output enable, hands the data bus from one port to the other. The select only moves while the enable is low, so the two ports never drive the bus at once.

A lock input keeps whichever port is being served as the only eligible port until lock drops. When both ports want the RAM and no lock is active, they take turns, and port A goes first after reset.

Top module: `dpram_arbiter`

## Requirements
- R1: A read or write request from a port counts only while that port's enable is high; without it no cycle starts.
- R2: `addr_sel` is 1 when port A is selected and 0 when port B is selected, and it names the granted port in the cycle `seq_start` is high.
- R3: `data_sel` is 1 for port A and 0 for port B, and it names the granted port in the cycle `seq_start` is high.
- R4: `data_sel` changes only while `data_oe` is low. `data_oe` is low during the start cycle and high from the following cycle until done is accepted.
- R5: While `lock` is high after a cycle has started, only the port that owned that cycle can be granted. The other port is served once `lock` falls.
- R6: `addr_sel` moves to the waiting port during a cycle only after `HOLD_CYC` cycles have passed since the start cycle. With `HOLD_CYC`=2, this happens three cycles after `seq_start`.
- R7: `seq_start` is a one-cycle pulse per grant. `seq_done` in a busy cycle produces a one-cycle `a_ack` or `b_ack` in the next cycle for the owner only.
- R8: A request that arrives during the other port's cycle is kept waiting and is granted directly after that cycle's acknowledge.
- R9: When both ports request at once, the grant goes to the port not served last. Port A is first after reset.
- R10: `seq_write` is 1 when the granted port's write line was high at grant; write wins if read and write are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_rd | input | 1 | Port A read request |
| a_wr | input | 1 | Port A write request |
| a_en | input | 1 | Port A enable qualifier |
| b_rd | input | 1 | Port B read request |
| b_wr | input | 1 | Port B write request |
| b_en | input | 1 | Port B enable qualifier |
| lock | input | 1 | Keep the current owner exclusive |
| seq_done | input | 1 | Sequencer reports the RAM cycle finished |
| seq_start | output | 1 | One-cycle start pulse to the sequencer |
| seq_write | output | 1 | Started cycle is a write |
| addr_sel | output | 1 | Address mux select, 1 = A |
| data_sel | output | 1 | Data port select, 1 = A |
| data_oe | output | 1 | Data port enable |
| a_ack | output | 1 | Port A acknowledge pulse |
| b_ack | output | 1 | Port B acknowledge pulse |

## Verification
The assertions assume that each port holds its request until it sees its acknowledge. They also assume that `seq_done` arrives only after `seq_start`, as a single-cycle pulse in a busy cycle. The stimulus keeps within these rules. It drives a request and keeps it up until the acknowledge cycle, drops it in that same cycle, and raises done for exactly one cycle, a few cycles after the start pulse. Lock is raised only while a cycle is running, so the captured owner is always well defined.

// File: rtl/dpram_arbiter.sv
module dpram_arbiter #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_rd,
  input  logic a_wr,
  input  logic a_en,
  input  logic b_rd,
  input  logic b_wr,
  input  logic b_en,
  input  logic lock,
  input  logic seq_done,
  output logic seq_start,
  output logic seq_write,
  output logic addr_sel,
  output logic data_sel,
  output logic data_oe,
  output logic a_ack,
  output logic b_ack
);
  localparam int CW = $clog2(HOLD_CYC + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_BUSY} st_t;
  st_t state;
  logic owner, last_a, lk_act, lk_own;
  logic [CW-1:0] cnt;

  wire blk_a  = lock & lk_act & ~lk_own;
  wire blk_b  = lock & lk_act &  lk_own;
  wire want_a = a_en & (a_rd | a_wr) & ~blk_a & ~a_ack;
  wire want_b = b_en & (b_rd | b_wr) & ~blk_b & ~b_ack;
  wire pick_a = want_a & (~want_b | ~last_a);
  wire grant  = (state == ST_IDLE) & (want_a | want_b);
  wire other  = owner ? want_b : want_a;
  wire hold_ok = cnt >= CW'(HOLD_CYC);

  assign seq_start = (state == ST_SETUP);
  assign data_oe   = (state == ST_BUSY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      owner <= 1'b1;
      last_a <= 1'b0;
      addr_sel <= 1'b1;
      data_sel <= 1'b1;
      seq_write <= 1'b0;
      cnt <= '0;
      a_ack <= 1'b0;
      b_ack <= 1'b0;
    end else begin
      a_ack <= 1'b0;
      b_ack <= 1'b0;
      case (state)
        ST_IDLE: if (grant) begin
          state <= ST_SETUP;
          owner <= pick_a;
          last_a <= pick_a;
          addr_sel <= pick_a;
          data_sel <= pick_a;
          seq_write <= pick_a ? a_wr : b_wr;
          cnt <= '0;
        end
        ST_SETUP: state <= ST_BUSY;
        ST_BUSY: begin
          if (hold_ok && other) addr_sel <= ~owner;
          if (seq_done) begin
            state <= ST_IDLE;
            a_ack <= owner;
            b_ack <= ~owner;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (state != ST_IDLE && cnt <= CW'(HOLD_CYC)) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_act <= 1'b0;
      lk_own <= 1'b1;
    end else if (!lock) begin
      lk_act <= 1'b0;
    end else if (!lk_act && state != ST_IDLE) begin
      lk_act <= 1'b1;
      lk_own <= owner;
    end
  end

  // R4
  data_sel_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_sel) |-> !data_oe);
  // R7
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_ack, b_ack}));
  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ack | b_ack) |=> !(a_ack | b_ack));
  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && addr_sel != owner) |-> cnt > CW'(HOLD_CYC));
  // R5
  lock_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && lk_act && state == ST_SETUP) |-> owner == lk_own);
  // R1
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !a_en && !b_en) |=> state != ST_SETUP);
  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);
endmodule

// File: tb/dpram_arbiter_bench.sv
module dpram_arbiter_bench;
  logic clk = 0, rst_n = 0;
  logic a_rd = 0, a_wr = 0, a_en = 0, b_rd = 0, b_wr = 0, b_en = 0;
  logic lock = 0, seq_done = 0;
  logic seq_start, seq_write, addr_sel, data_sel, data_oe, a_ack, b_ack;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dpram_arbiter #(.HOLD_CYC(2)) u_dpram_arbiter (.*);

  // {a_rd,a_wr,a_en,b_rd,b_wr,b_en, expect_A, expect_write}
  localparam logic [7:0] VEC [6] = '{
    8'b10100010, 8'b00001101, 8'b10101110,
    8'b01110100, 8'b10010100, 8'b11100011};

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic drop_all();
    a_rd = 0; a_wr = 0; a_en = 0; b_rd = 0; b_wr = 0; b_en = 0;
  endtask

  task automatic wait_start();
    for (int i = 0; i < 30 && seq_start !== 1'b1; i++) @(negedge clk);
    chk("R7 start seen", seq_start, 1'b1);
  endtask

  task automatic finish_cycle(input logic exp_a);
    seq_done = 1;
    @(negedge clk);
    seq_done = 0;
    chk("R7 owner ack", exp_a ? a_ack : b_ack, 1'b1);
    chk("R7 other ack low", exp_a ? b_ack : a_ack, 1'b0);
  endtask

  task automatic serve(input logic exp_a, input logic exp_wr, input string tag);
    wait_start();
    chk({tag, " R2 addr_sel"}, addr_sel, exp_a);
    chk({tag, " R3 data_sel"}, data_sel, exp_a);
    chk({tag, " R10 seq_write"}, seq_write, exp_wr);
    chk({tag, " R4 oe low at start"}, data_oe, 1'b0);
    @(negedge clk);
    chk({tag, " R4 oe high busy"}, data_oe, 1'b1);
    chk({tag, " R7 start one cycle"}, seq_start, 1'b0);
    @(negedge clk);
    finish_cycle(exp_a);
    drop_all();
    @(negedge clk);
    chk({tag, " R7 ack one cycle"}, a_ack | b_ack, 1'b0);
  endtask

  initial begin
    #(20000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    if (!finished) $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset seq_start", seq_start, 1'b0);
    chk("reset data_oe", data_oe, 1'b0);
    chk("reset acks", a_ack | b_ack, 1'b0);
    chk("R2 reset addr_sel", addr_sel, 1'b1);

    // R9 R10 R2 R3 table
    foreach (VEC[i]) begin
      {a_rd, a_wr, a_en, b_rd, b_wr, b_en} = VEC[i][7:2];
      serve(VEC[i][1], VEC[i][0], $sformatf("R9 vec%0d", i));
    end

    // R1: requests without enable
    a_rd = 1; b_wr = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R1 no start without enable", seq_start, 1'b0);
    end
    drop_all();

    // R8 R6: B arrives during A's cycle
    a_rd = 1; a_en = 1;
    wait_start();
    b_rd = 1; b_en = 1;
    @(negedge clk);
    chk("R6 addr held c1", addr_sel, 1'b1);
    @(negedge clk);
    chk("R6 addr held c2", addr_sel, 1'b1);
    @(negedge clk);
    chk("R6 addr early switch", addr_sel, 1'b0);
    chk("R4 data_sel kept", data_sel, 1'b1);
    finish_cycle(1'b1);
    a_rd = 0; a_en = 0;
    serve(1'b0, 1'b0, "R8 pending B");

    // R5: lock keeps A exclusive
    a_wr = 1; a_en = 1;
    wait_start();
    lock = 1; b_rd = 1; b_en = 1;
    repeat (3) @(negedge clk);
    chk("R5 addr not switched under lock", addr_sel, 1'b1);
    finish_cycle(1'b1);
    a_wr = 0; a_en = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R5 B locked out", seq_start, 1'b0);
    end
    a_rd = 1; a_en = 1;
    serve(1'b1, 1'b0, "R5 owner again");
    b_rd = 1; b_en = 1;
    lock = 0;
    serve(1'b0, 1'b0, "R5 after release");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule